// File: doc/BRIEF.md
# Receive FIFO Rejection Filter

This block sits between frame reception and the receive FIFO of a time-triggered bus controller. The receiver hands it each valid frame that found no dedicated receive buffer. The block then decides whether that frame may enter the FIFO. The decision works by rejection. A frame is refused when it matches the programmed rejection pattern, or when one of two overrides applies. Any other frame is admitted.

The rejection pattern has three parts, and all three must match before the frame is refused:

- **Channel part.** A two-bit field holds one bit per receive channel.
- **Frame-ID part.** An 11-bit identifier pattern is compared under a don't-care mask.
- **Cycle part.** A base value and a power-of-two repetition are compared against the 6-bit cycle count.

The two overrides work on their own. One refuses every frame that arrived in the static segment. The other refuses null frames. When the null override is clear, a null frame is judged exactly as a data frame would be. Both override enables live in configuration registers outside this block, and those registers reset to 1.

The decision is registered. It appears one clock after the frame strobe, together with a one-cycle valid pulse.

Top module: `rxfifo_reject_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it was high, `dec_valid` and `dec_accept` are 0.
- R2: `dec_valid` is 1 exactly in the cycle after a cycle with `frm_valid` high, and 0 otherwise. `dec_accept` is 0 whenever `dec_valid` is 0. Frames on consecutive cycles each get their own decision.
- R3: The channel part matches when bit `frm_chan` of `cfg_pat_chan` is 1. Bit 0 stands for channel A (`frm_chan`=0) and bit 1 for channel B (`frm_chan`=1). A frame whose channel bit is 0 is accepted unless an override applies.
- R4: The frame-ID part matches when `frm_id` equals `cfg_pat_id` in every bit position where `cfg_id_mask` is 0. A mask bit of 1 makes that position don't care.
- R5: The cycle part matches when `frm_cyc` modulo 2^E equals `cfg_cyc_base`, where E is `cfg_cyc_exp` clamped to at most 6. If the base is 2^E or more, the cycle part never matches.
- R6: A frame with no override active is rejected (`dec_accept`=0) only when the channel, frame-ID and cycle parts all match. Otherwise it is accepted (`dec_accept`=1).
- R7: When both `cfg_rej_static` and `frm_static` are 1, the frame is rejected regardless of the pattern.
- R8: When both `cfg_rej_null` and `frm_null` are 1, the frame is rejected. When `cfg_rej_null` is 0, a null frame gets the same decision as an otherwise identical data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pat_chan | input | 2 | Channel rejection bits (bit 0 = A, bit 1 = B) |
| cfg_pat_id | input | ID_W | Frame-ID rejection pattern |
| cfg_id_mask | input | ID_W | Frame-ID don't-care mask (1 = ignore bit) |
| cfg_cyc_base | input | CYC_W | Cycle filter base value |
| cfg_cyc_exp | input | EXP_W | Cycle repetition exponent (repetition = 2^exp, clamped) |
| cfg_rej_static | input | 1 | Refuse all static-segment frames |
| cfg_rej_null | input | 1 | Refuse null frames |
| frm_valid | input | 1 | Candidate frame strobe |
| frm_chan | input | 1 | Receive channel (0 = A, 1 = B) |
| frm_id | input | ID_W | Frame identifier |
| frm_cyc | input | CYC_W | Cycle count of reception |
| frm_static | input | 1 | Frame was received in the static segment |
| frm_null | input | 1 | Frame is a null frame |
| dec_valid | output | 1 | Decision valid pulse |
| dec_accept | output | 1 | 1 = admit to FIFO, 0 = refuse |

## Verification
The bench uses the default widths: an 11-bit frame ID and a 6-bit cycle count. That makes the exponent field 3 bits wide. It can therefore encode the out-of-range value 7, which lets the bench exercise the clamp to a 64-cycle repetition alongside every legal repetition from 1 to 64. It can also pair a base value that exceeds the repetition with an otherwise fully matching frame. The 11-bit identifier lets the bench test single-bit mask holes at both the lowest and the highest ID bit.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } rx_chan_e;

    typedef struct packed {
        logic chan_hit;
        logic id_hit;
        logic cyc_hit;
    } hit_vec_t;

    typedef struct packed {
        logic valid;
        logic accept;
    } decision_t;

    // Pattern hit needs every sub-filter; overrides refuse on their own.
    function automatic logic is_refused(hit_vec_t h,
                                        logic st_en, logic st,
                                        logic nu_en, logic nu);
        logic pat;
        pat = h.chan_hit & h.id_hit & h.cyc_hit;
        return pat | (st_en & st) | (nu_en & nu);
    endfunction

endpackage

// File: rtl/rxfr_id_cmp.sv
module rxfr_id_cmp #(
    parameter int ID_W = 11
) (
    input  logic [ID_W-1:0] id_in,
    input  logic [ID_W-1:0] pat,
    input  logic [ID_W-1:0] dont_care,
    output logic            hit
);
    logic [ID_W-1:0] bit_ok;

    for (genvar i = 0; i < ID_W; i++) begin : g_bit
        assign bit_ok[i] = dont_care[i] | ~(id_in[i] ^ pat[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/rxfr_cyc_cmp.sv
module rxfr_cyc_cmp #(
    parameter int CYC_W = 6,
    parameter int EXP_W = $clog2(CYC_W + 1)
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic [CYC_W-1:0] base,
    input  logic [EXP_W-1:0] rep_exp,
    output logic             hit
);
    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(CYC_W);

    logic [EXP_W-1:0] exp_c;
    logic [CYC_W-1:0] keep;

    always_comb begin
        exp_c = (rep_exp > EXP_MAX) ? EXP_MAX : rep_exp;
    end

    // Low exp_c bits form the residue modulo 2^exp_c.
    for (genvar i = 0; i < CYC_W; i++) begin : g_keep
        assign keep[i] = (exp_c > EXP_W'(i));
    end

    // Full-width base compare: base bits above the residue must be zero.
    assign hit = ((cyc & keep) == base);
endmodule

// File: rtl/rxfifo_reject_filter.sv
module rxfifo_reject_filter
    import rxfr_pkg::*;
#(
    parameter int ID_W  = 11,
    parameter int CYC_W = 6,
    parameter int EXP_W = $clog2(CYC_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_pat_chan,
    input  logic [ID_W-1:0]  cfg_pat_id,
    input  logic [ID_W-1:0]  cfg_id_mask,
    input  logic [CYC_W-1:0] cfg_cyc_base,
    input  logic [EXP_W-1:0] cfg_cyc_exp,
    input  logic             cfg_rej_static,
    input  logic             cfg_rej_null,
    input  logic             frm_valid,
    input  logic             frm_chan,
    input  logic [ID_W-1:0]  frm_id,
    input  logic [CYC_W-1:0] frm_cyc,
    input  logic             frm_static,
    input  logic             frm_null,
    output logic             dec_valid,
    output logic             dec_accept
);
    hit_vec_t  hits;
    rx_chan_e  chan;
    decision_t dec_d, dec_q;
    logic      id_hit, cyc_hit;

    assign chan = rx_chan_e'(frm_chan);

    rxfr_id_cmp #(.ID_W(ID_W)) u_id (
        .id_in     (frm_id),
        .pat       (cfg_pat_id),
        .dont_care (cfg_id_mask),
        .hit       (id_hit)
    );

    rxfr_cyc_cmp #(.CYC_W(CYC_W), .EXP_W(EXP_W)) u_cyc (
        .cyc     (frm_cyc),
        .base    (cfg_cyc_base),
        .rep_exp (cfg_cyc_exp),
        .hit     (cyc_hit)
    );

    always_comb begin
        hits.chan_hit = (chan == CH_B) ? cfg_pat_chan[1] : cfg_pat_chan[0];
        hits.id_hit   = id_hit;
        hits.cyc_hit  = cyc_hit;
        dec_d.valid   = frm_valid;
        dec_d.accept  = frm_valid & ~is_refused(hits, cfg_rej_static, frm_static,
                                                cfg_rej_null, frm_null);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
endmodule

// File: rtl/rxfr_checker.sv
module rxfr_checker #(
    parameter int ID_W  = 11,
    parameter int CYC_W = 6,
    parameter int EXP_W = $clog2(CYC_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_pat_chan,
    input logic [ID_W-1:0]  cfg_id_mask,
    input logic             cfg_rej_static,
    input logic             cfg_rej_null,
    input logic             frm_valid,
    input logic             frm_chan,
    input logic             frm_static,
    input logic             frm_null,
    input logic             dec_valid,
    input logic             dec_accept
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dec_valid && !dec_accept));

    // R2
    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> dec_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !dec_valid);
    a_r2_accept_qualified: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_accept);

    // R3
    a_r3_chan_miss_admits: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !cfg_pat_chan[frm_chan]
         && !(cfg_rej_static && frm_static) && !(cfg_rej_null && frm_null))
        |=> dec_accept);

    // R4: an all-ones mask hides every ID bit, so a full pattern needs only channel+cycle
    a_r4_mask_sane: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && (&cfg_id_mask) && !cfg_pat_chan[frm_chan]) |=> dec_valid);

    // R7
    a_r7_static_refused: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && cfg_rej_static && frm_static) |=> !dec_accept);

    // R8
    a_r8_null_refused: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && cfg_rej_null && frm_null) |=> !dec_accept);
endmodule

bind rxfifo_reject_filter rxfr_checker #(
    .ID_W(ID_W), .CYC_W(CYC_W), .EXP_W(EXP_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_pat_chan   (cfg_pat_chan),
    .cfg_id_mask    (cfg_id_mask),
    .cfg_rej_static (cfg_rej_static),
    .cfg_rej_null   (cfg_rej_null),
    .frm_valid      (frm_valid),
    .frm_chan       (frm_chan),
    .frm_static     (frm_static),
    .frm_null       (frm_null),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept)
);

// File: tb/sim_rxfifo_reject_filter.sv
`timescale 1ns/1ps
module sim_rxfifo_reject_filter;
    localparam int ID_W  = 11;
    localparam int CYC_W = 6;
    localparam int EXP_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_pat_chan = 2'b11;
    logic [ID_W-1:0]  cfg_pat_id = '0;
    logic [ID_W-1:0]  cfg_id_mask = '0;
    logic [CYC_W-1:0] cfg_cyc_base = '0;
    logic [EXP_W-1:0] cfg_cyc_exp = '0;
    logic             cfg_rej_static = 1'b1;
    logic             cfg_rej_null = 1'b1;
    logic             frm_valid = 1'b0;
    logic             frm_chan = 1'b0;
    logic [ID_W-1:0]  frm_id = '0;
    logic [CYC_W-1:0] frm_cyc = '0;
    logic             frm_static = 1'b0;
    logic             frm_null = 1'b0;
    logic             dec_valid, dec_accept;

    int vectors = 0;
    int miscompares = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    rxfifo_reject_filter #(.ID_W(ID_W), .CYC_W(CYC_W), .EXP_W(EXP_W)) u0 (
        .clk(clk), .rst(rst),
        .cfg_pat_chan(cfg_pat_chan), .cfg_pat_id(cfg_pat_id),
        .cfg_id_mask(cfg_id_mask), .cfg_cyc_base(cfg_cyc_base),
        .cfg_cyc_exp(cfg_cyc_exp), .cfg_rej_static(cfg_rej_static),
        .cfg_rej_null(cfg_rej_null), .frm_valid(frm_valid),
        .frm_chan(frm_chan), .frm_id(frm_id), .frm_cyc(frm_cyc),
        .frm_static(frm_static), .frm_null(frm_null),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input string req, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Independent reference taken from the requirement text.
    function automatic logic model_accept(logic ch, logic [ID_W-1:0] id,
                                          logic [CYC_W-1:0] cyc, logic st, logic nu);
        logic id_ok;
        logic cyc_ok;
        int   e;
        int   rep;
        id_ok = 1'b1;
        for (int b = 0; b < ID_W; b++)
            if (!cfg_id_mask[b] && (id[b] != cfg_pat_id[b])) id_ok = 1'b0;
        e = int'(cfg_cyc_exp);
        if (e > CYC_W) e = CYC_W;
        rep = 1 << e;
        cyc_ok = ((int'(cyc) % rep) == int'(cfg_cyc_base));
        if (cfg_rej_static && st) return 1'b0;
        if (cfg_rej_null && nu) return 1'b0;
        return !(cfg_pat_chan[ch] && id_ok && cyc_ok);
    endfunction

    task automatic send(input string req, input logic ch, input logic [ID_W-1:0] id,
                        input logic [CYC_W-1:0] cyc, input logic st, input logic nu);
        logic exp;
        @(negedge clk);
        frm_chan = ch; frm_id = id; frm_cyc = cyc; frm_static = st; frm_null = nu;
        frm_valid = 1'b1;
        exp = model_accept(ch, id, cyc, st, nu);
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, dec_valid, 1'b1);
        check(req, dec_accept, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid", dec_valid, 1'b0);
        check("R1 accept", dec_accept, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", dec_valid, 1'b0);
    endtask

    task automatic t_timing();
        cfg_rej_static = 1'b0; cfg_rej_null = 1'b0;
        cfg_pat_chan = 2'b11; cfg_pat_id = 11'h055; cfg_id_mask = '0;
        cfg_cyc_base = 6'd0; cfg_cyc_exp = 3'd0;
        send("R2 single", 1'b0, 11'h055, 6'd9, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 idle", dec_valid, 1'b0);
        check("R2 idle accept", dec_accept, 1'b0);
        // back-to-back: reject then accept
        @(negedge clk);
        frm_valid = 1'b1; frm_id = 11'h055; frm_chan = 1'b0; frm_cyc = 6'd3;
        frm_static = 1'b0; frm_null = 1'b0;
        @(negedge clk);
        frm_id = 11'h056;
        check("R2 b2b first valid", dec_valid, 1'b1);
        check("R2 b2b first", dec_accept, 1'b0);
        @(negedge clk);
        frm_valid = 1'b0;
        check("R2 b2b second valid", dec_valid, 1'b1);
        check("R2 b2b second", dec_accept, 1'b1);
    endtask

    task automatic t_channel();
        cfg_pat_id = 11'h100; cfg_id_mask = '0; cfg_cyc_exp = 3'd0; cfg_cyc_base = 6'd0;
        cfg_pat_chan = 2'b01;
        send("R3 A hit", 1'b0, 11'h100, 6'd5, 1'b0, 1'b0);
        send("R3 B miss", 1'b1, 11'h100, 6'd5, 1'b0, 1'b0);
        cfg_pat_chan = 2'b10;
        send("R3 A miss", 1'b0, 11'h100, 6'd5, 1'b0, 1'b0);
        send("R3 B hit", 1'b1, 11'h100, 6'd5, 1'b0, 1'b0);
        cfg_pat_chan = 2'b00;
        send("R3 none", 1'b1, 11'h100, 6'd5, 1'b0, 1'b0);
    endtask

    task automatic t_id_mask();
        cfg_pat_chan = 2'b11; cfg_pat_id = 11'h2A5; cfg_cyc_exp = 3'd0; cfg_cyc_base = 6'd0;
        cfg_id_mask = '0;
        send("R4 exact", 1'b0, 11'h2A5, 6'd1, 1'b0, 1'b0);
        send("R4 lsb diff", 1'b0, 11'h2A4, 6'd1, 1'b0, 1'b0);
        send("R4 msb diff", 1'b0, 11'h6A5, 6'd1, 1'b0, 1'b0);
        cfg_id_mask = 11'h001;
        send("R4 lsb masked", 1'b0, 11'h2A4, 6'd1, 1'b0, 1'b0);
        cfg_id_mask = 11'h400;
        send("R4 msb masked", 1'b0, 11'h6A5, 6'd1, 1'b0, 1'b0);
        send("R4 other bit", 1'b0, 11'h2A7, 6'd1, 1'b0, 1'b0);
        cfg_id_mask = 11'h7FF;
        send("R4 all masked", 1'b1, 11'h013, 6'd1, 1'b0, 1'b0);
    endtask

    task automatic t_cycle();
        cfg_pat_chan = 2'b11; cfg_id_mask = 11'h7FF;
        for (int e = 0; e < 8; e++) begin
            cfg_cyc_exp = EXP_W'(e);
            cfg_cyc_base = 6'd1;
            send("R5 base1 c1", 1'b0, 11'h0, 6'd1, 1'b0, 1'b0);
            send("R5 base1 c33", 1'b0, 11'h0, 6'd33, 1'b0, 1'b0);
            send("R5 base1 c2", 1'b0, 11'h0, 6'd2, 1'b0, 1'b0);
        end
        cfg_cyc_exp = 3'd2; cfg_cyc_base = 6'd5;
        send("R5 base over rep", 1'b0, 11'h0, 6'd5, 1'b0, 1'b0);
        cfg_cyc_exp = 3'd7; cfg_cyc_base = 6'd63;
        send("R5 clamp hit", 1'b0, 11'h0, 6'd63, 1'b0, 1'b0);
        send("R5 clamp miss", 1'b0, 11'h0, 6'd31, 1'b0, 1'b0);
    endtask

    task automatic t_pattern();
        cfg_pat_chan = 2'b01; cfg_pat_id = 11'h0F0; cfg_id_mask = 11'h00F;
        cfg_cyc_exp = 3'd3; cfg_cyc_base = 6'd4;
        send("R6 all match", 1'b0, 11'h0F9, 6'd12, 1'b0, 1'b0);
        send("R6 cyc fails", 1'b0, 11'h0F9, 6'd13, 1'b0, 1'b0);
        send("R6 id fails", 1'b0, 11'h1F9, 6'd12, 1'b0, 1'b0);
        send("R6 chan fails", 1'b1, 11'h0F9, 6'd12, 1'b0, 1'b0);
    endtask

    task automatic t_static();
        cfg_pat_chan = 2'b00;
        cfg_rej_static = 1'b1;
        send("R7 static refused", 1'b0, 11'h123, 6'd7, 1'b1, 1'b0);
        send("R7 dynamic passes", 1'b0, 11'h123, 6'd7, 1'b0, 1'b0);
        cfg_rej_static = 1'b0;
        send("R7 disabled", 1'b0, 11'h123, 6'd7, 1'b1, 1'b0);
    endtask

    task automatic t_null();
        cfg_rej_static = 1'b0;
        cfg_pat_chan = 2'b00;
        cfg_rej_null = 1'b1;
        send("R8 null refused", 1'b1, 11'h321, 6'd2, 1'b0, 1'b1);
        cfg_rej_null = 1'b0;
        send("R8 null like data", 1'b1, 11'h321, 6'd2, 1'b0, 1'b1);
        cfg_pat_chan = 2'b10; cfg_pat_id = 11'h321; cfg_id_mask = '0;
        cfg_cyc_exp = 3'd0; cfg_cyc_base = 6'd0;
        send("R8 null pattern", 1'b1, 11'h321, 6'd2, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_channel();
        t_id_mask();
        t_cycle();
        t_pattern();
        t_static();
        t_null();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule